// File: doc/BRIEF.md
# Multi-Converter Priority Result Collector

This block gathers results from as many as seven data converters. Each converter reports a finished conversion by pulling its own completion flag low. When the collector is idle and sees any flag low, it takes a snapshot of every flag into a status word. It then reads only the converters that the snapshot shows as requesting, and always visits the lowest-numbered converter first.

Each converter is read with a one-cycle strobe of its own, and its data byte is taken from a shared 8-bit bus. The collector stores that byte in a circular result buffer. An identifier byte follows at the next location, and its value is the converter number (1 to 7). Software that walks the buffer can therefore tell which source every byte came from. Converters may be started in any order. A flag that goes low after the snapshot is handled in the following pass. The buffer length is a run-time input, and the write pointer wraps at that length.

Top module: `prio_irq_servicer`

## Requirements
- R1: While reset is asserted, and after it is released, no read strobe and no buffer write is active until a flag goes low. The first buffer write after reset goes to address 0.
- R2: A service pass begins only from idle and only when at least one flag is low. At that edge the flags are latched into the status word: bit k-1 stands for converter k, and a 0 means a request.
- R3: Within a pass, requesting converters are read in ascending number order, so converter 1 has the highest priority and converter 7 the lowest.
- R4: At most one read strobe is high in any cycle, and each strobe lasts one cycle. A strobe goes only to a converter whose bit is 0 in the status word.
- R5: For every converter that is read, two bytes are written: first the data byte, then, at the next location, the identifier equal to the converter number (1 to 7; 0 is never used as an identifier).
- R6: A flag that goes low after the snapshot is not served in the current pass, even if its converter has higher priority. It is served in the next pass.
- R7: The write address advances by one on every buffer write and returns to 0 when the next value would reach buf_len. A buf_len of 0 or 1 keeps every write at address 0.
- R8: The data byte is written in the cycle right after the read strobe, and the identifier is written in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_n | input | NUM_CVT | Completion flags, active low, one per converter |
| cvt_rd | output | NUM_CVT | One-cycle read strobes, one per converter |
| rd_data | input | DATA_W | Shared data bus, valid during the strobe cycle |
| buf_len | input | ADDR_W+1 | Buffer length at which the write pointer wraps |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data (data byte or identifier) |

## Verification
The bench raises a request from a low-priority converter, then raises one from converter 1 a single cycle after the snapshot. A collector that rescanned live flags instead of its snapshot would serve converter 1 first. Random subsets of flags check the ascending order and the skipping of idle converters; a design with a faulty priority chain writes identifiers out of order or strobes a converter that is not requesting. A buffer length of 7 puts a data byte at the last slot and its identifier at slot 0, which catches an off-by-one in the wrap. A length of 1 pins every write to address 0. Each data write is also checked to follow a strobe in the previous cycle, which exposes a design that misplaces the capture cycle.

// File: rtl/pis_pkg.sv
`timescale 1ns/1ps
package pis_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_WDAT = 2'd2,
      ST_WID  = 2'd3
   } svc_state_e;
endpackage

// File: rtl/pis_pick.sv
`timescale 1ns/1ps
module pis_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/pis_wptr.sv
`timescale 1ns/1ps
module pis_wptr #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [ADDR_W:0]   len,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W:0] inc;
   assign inc = {1'b0, ptr} + (ADDR_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (adv)    ptr <= (inc >= len) ? '0 : inc[ADDR_W-1:0];
   end
endmodule

// File: rtl/prio_irq_servicer.sv
`timescale 1ns/1ps
module prio_irq_servicer #(
   parameter int NUM_CVT = 7,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CVT-1:0] done_n,
   output logic [NUM_CVT-1:0] cvt_rd,
   input  logic [DATA_W-1:0]  rd_data,
   input  logic [ADDR_W:0]    buf_len,
   output logic               buf_we,
   output logic [ADDR_W-1:0]  buf_addr,
   output logic [DATA_W-1:0]  buf_wdata
);
   import pis_pkg::*;

   if (NUM_CVT < 1 || NUM_CVT > 7) begin : g_bad_num
      $error("NUM_CVT must lie in 1..7");
   end
   if (DATA_W < 3) begin : g_bad_dw
      $error("DATA_W must hold an identifier up to 7");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("ADDR_W must be at least 1");
   end

   svc_state_e          state_q;
   logic [NUM_CVT-1:0]  status_q;
   logic [NUM_CVT-1:0]  cur_q;
   logic [DATA_W-1:0]   data_q;
   logic [NUM_CVT-1:0]  grant;
   logic                any_req;
   logic [DATA_W-1:0]   cur_id;

   pis_pick #(.N(NUM_CVT)) u_pick (
      .req   (~status_q),
      .grant (grant),
      .any   (any_req)
   );

   pis_wptr #(.ADDR_W(ADDR_W)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (buf_we),
      .len   (buf_len),
      .ptr   (buf_addr)
   );

   always_comb begin
      cur_id = '0;
      for (int i = 0; i < NUM_CVT; i++)
         if (cur_q[i]) cur_id = DATA_W'(i + 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         status_q <= '1;
         cur_q    <= '0;
         data_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (!(&done_n)) begin
               status_q <= done_n;
               state_q  <= ST_READ;
            end
            ST_READ: if (any_req) begin
               cur_q   <= grant;
               data_q  <= rd_data;
               state_q <= ST_WDAT;
            end else begin
               state_q <= ST_IDLE;
            end
            ST_WDAT: state_q <= ST_WID;
            ST_WID: begin
               status_q <= status_q | cur_q;
               state_q  <= ST_READ;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cvt_rd    = (state_q == ST_READ) ? grant : '0;
   assign buf_we    = (state_q == ST_WDAT) || (state_q == ST_WID);
   assign buf_wdata = (state_q == ST_WID) ? cur_id : data_q;
endmodule

// File: rtl/prio_irq_servicer_chk.sv
`timescale 1ns/1ps
module prio_irq_servicer_chk #(
   parameter int NUM_CVT = 7,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_CVT-1:0] cvt_rd,
   input logic [NUM_CVT-1:0] status_q,
   input logic               buf_we,
   input logic [ADDR_W-1:0]  buf_addr,
   input logic [DATA_W-1:0]  buf_wdata,
   input logic [ADDR_W:0]    buf_len
);
   function automatic logic [DATA_W-1:0] num_of(logic [NUM_CVT-1:0] oh);
      logic [DATA_W-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_CVT; i++)
         if (oh[i]) r = DATA_W'(i + 1);
      return r;
   endfunction

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cvt_rd));                                                    // R4
   AST_STROBE_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cvt_rd & status_q) == '0);                                           // R4
   AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (|cvt_rd) |=> !(|cvt_rd));                                            // R4
   AST_DATA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (|cvt_rd) |=> buf_we);                                                // R8
   AST_ID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|cvt_rd) |=> ##1 (buf_we && buf_wdata == num_of($past(cvt_rd, 2)))); // R5
   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_len > 1) |-> ({1'b0, buf_addr} < buf_len));             // R7
endmodule

bind prio_irq_servicer prio_irq_servicer_chk #(
   .NUM_CVT(NUM_CVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cvt_rd    (cvt_rd),
   .status_q  (status_q),
   .buf_we    (buf_we),
   .buf_addr  (buf_addr),
   .buf_wdata (buf_wdata),
   .buf_len   (buf_len)
);

// File: tb/prio_irq_servicer_bench.sv
`timescale 1ns/1ps
module prio_irq_servicer_bench;
   localparam int N  = 7;
   localparam int DW = 8;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  done_n = '1;
   logic [N-1:0]  start_pulse = '0;
   logic [N-1:0]  cvt_rd;
   logic [DW-1:0] rd_data;
   logic [AW:0]   buf_len = 7'd40;
   logic          buf_we;
   logic [AW-1:0] buf_addr;
   logic [DW-1:0] buf_wdata;

   logic [DW-1:0] val [N];
   logic [DW-1:0] mem [1 << AW];
   int            exp_addr [512];
   int            exp_data [512];
   int            eidx = 0, widx = 0, eptr = 0;
   int            nchk = 0, nerr = 0;
   logic [N-1:0]  prev_rd = '0;
   bit            finished = 0;

   always #2 clk = ~clk;

   prio_irq_servicer #(.NUM_CVT(N), .DATA_W(DW), .ADDR_W(AW)) u_prio_irq_servicer (
      .clk(clk), .rst_n(rst_n), .done_n(done_n), .cvt_rd(cvt_rd), .rd_data(rd_data),
      .buf_len(buf_len), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
   );

   // converter models: a strobe clears the flag, a start pulse sets it low
   always @(posedge clk) begin
      done_n <= (done_n | cvt_rd) & ~start_pulse;
      if (buf_we) mem[buf_addr] <= buf_wdata;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N; k++)
         if (cvt_rd[k]) rd_data = rd_data | val[k];
   end

   task automatic fail(string msg);
      nerr++;
      $display("FAIL %s", msg);
   endtask

   function automatic int next_ptr(int p);
      return (p + 1 >= int'(buf_len)) ? 0 : p + 1;
   endfunction

   task automatic push(int d);
      exp_addr[eidx] = eptr;
      exp_data[eidx] = d;
      eidx++;
      eptr = next_ptr(eptr);
   endtask

   task automatic expect_conv(int k);
      push(int'(val[k]));
      push(k + 1);
   endtask

   task automatic expect_pass(logic [N-1:0] m);
      for (int k = 0; k < N; k++)
         if (m[k]) expect_conv(k);
   endtask

   task automatic fire(logic [N-1:0] m);
      @(negedge clk) start_pulse = m;
      @(negedge clk) start_pulse = '0;
   endtask

   // monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         nchk++;
         if (cvt_rd != '0 || buf_we)
            fail($sformatf("R1 reset: rd=%0h we=%0b expected rd=0 we=0", cvt_rd, buf_we));
      end else begin
         if (|cvt_rd) begin
            nchk++;
            if ($countones(cvt_rd) != 1 || (cvt_rd & done_n) != '0)
               fail($sformatf("R4 strobe=%0h flags=%0h expected one strobe to a low flag",
                              cvt_rd, done_n));
         end
         if (buf_we) begin
            nchk++;
            if (widx >= eidx)
               fail($sformatf("R2 unexpected write addr=%0d data=%0h expected none",
                              buf_addr, buf_wdata));
            else if (int'(buf_addr) != exp_addr[widx] || int'(buf_wdata) != exp_data[widx])
               fail($sformatf("R3/R5/R7 write %0d: addr=%0d data=%0h expected addr=%0d data=%0h",
                              widx, buf_addr, buf_wdata, exp_addr[widx], exp_data[widx]));
            else if (widx % 2 == 0 && prev_rd == '0)
               fail($sformatf("R8 data write %0d: prior strobe=%0h expected nonzero", widx, prev_rd));
            widx++;
         end
      end
      prev_rd = cvt_rd;
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      fail("watchdog expired: got hang expected completion");
      finish_run();
   end

   task automatic do_reset(logic [AW:0] len);
      @(negedge clk) rst_n = 1'b0;
      buf_len = len;
      eptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      logic [N-1:0] m;
      int           p0;
      void'($urandom(32'd4711));
      for (int k = 0; k < N; k++) val[k] = DW'(8'h10 * (k + 1) + k);
      do_reset(7'd40);

      // R1: first write at address 0; R3/R5: all seven at once
      expect_pass('1);
      fire('1);
      repeat (30) @(negedge clk);

      // R6: converter 3 snapshot, converter 1 arrives one cycle later
      p0 = eptr;
      expect_conv(2);
      expect_conv(0);
      @(negedge clk) start_pulse = 7'b0000100;
      @(negedge clk) start_pulse = 7'b0000001;
      @(negedge clk) start_pulse = '0;
      repeat (30) @(negedge clk);
      nchk++;
      if (mem[p0 + 1] != 8'd3 || mem[p0 + 3] != 8'd1)
         fail($sformatf("R6 ids=%0d,%0d expected 3,1", mem[p0 + 1], mem[p0 + 3]));

      // R2/R3/R4: random subsets and data
      for (int t = 0; t < 24; t++) begin
         m = N'($urandom);
         if (m == '0) m = 7'b1000000;
         for (int k = 0; k < N; k++) val[k] = DW'($urandom);
         expect_pass(m);
         fire(m);
         repeat (30) @(negedge clk);
      end

      // R7: wrap at length 7 splits a data/id pair across the wrap
      do_reset(7'd7);
      for (int t = 0; t < 6; t++) begin
         m = N'($urandom) | 7'b0000010;
         for (int k = 0; k < N; k++) val[k] = DW'($urandom);
         expect_pass(m);
         fire(m);
         repeat (30) @(negedge clk);
      end

      // R7: length 1 pins every write to address 0
      do_reset(7'd1);
      expect_pass(7'b1000011);
      fire(7'b1000011);
      repeat (30) @(negedge clk);

      nchk++;
      if (widx != eidx)
         fail($sformatf("R5 write count=%0d expected %0d", widx, eidx));
      finish_run();
   end
endmodule